// File: doc/BRIEF.md
# Serial Receiver Configuration Loader

This block receives configuration commands for a radio receiver over a three-wire serial link (frame enable, serial clock, serial data) and holds the receiver's two 12-bit setup registers: an operating-mode register (baud range, bit-check count, sensitivity select, sleep time and two sleep-extension flags) and a limit register (lower and upper bit-check limits). The serial inputs are synchronized into the core clock domain and shifted in MSB first on each rising serial clock edge.

A frame is a variable-length command. A leading 1 on its own is a complete OFF command, which produces a single-cycle pulse telling the receiver to go back to polling. A leading 0 starts a 14-bit programming word: the second bit picks the register and the following twelve bits are its new contents, committed as a whole one clock after the last bit. Frames cut short leave everything unchanged.

Each register keeps a parity bit. When the stored contents no longer match their parity (a supply-drop upset, modelled by the `upset_i` input), a sticky reset-marker output is raised and stays up until every corrupted register has been rewritten by software. Asynchronous reset loads both registers with fixed defaults.

Top module: `rx_cfg_loader`

## Requirements
- R1: After reset the mode fields read baud range 0, bit-check 2, sensitivity select 0 (full sensitivity), sleep 11, both sleep-extension flags 0.
- R2: After reset the lower limit reads 14 and the upper limit reads 24; the reset marker is 0.
- R3: A frame of 14 or more bits whose first bit is 0 and second bit is 1 loads bits 3 to 14 into the mode register, in the order baud[1:0], bitchk[1:0], pout, sleep[4:0], xsleep_std, xsleep_temp.
- R4: A frame whose first bit is 0 and second bit is 0 loads bits 3 to 14 into the limit register as lim_min[5:0] then lim_max[5:0].
- R5: A frame whose first bit is 1 raises off_pulse_o for exactly one clock cycle, whatever bits follow, and changes neither register.
- R6: A frame ending after fewer than 14 bits with a first bit of 0 changes no register and raises no off pulse.
- R7: Bits after the 14th in a frame are ignored.
- R8: An upset of a register raises reset_marker_o, which stays high until every upset register has since been written by a complete programming word.
- R9: While a word is being shifted in, the field outputs keep their previous values; they change only after the 14th bit.
- R10: A new frame after an aborted or completed one starts decoding again from bit 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Core clock |
| rst_ni | input | 1 | Active-low asynchronous power-on reset |
| frame_i | input | 1 | Frame enable; high for the duration of one command |
| sclk_i | input | 1 | Serial clock; data sampled on its rising edge |
| sdata_i | input | 1 | Serial data, MSB first |
| upset_i | input | 2 | Storage upset model: bit 1 flips the mode register LSB, bit 0 the limit register LSB |
| baud_o | output | 2 | Baud range select |
| bitchk_o | output | 2 | Bit-check count select |
| pout_o | output | 1 | 1 selects reduced sensitivity |
| sleep_o | output | 5 | Sleep time |
| xsleep_std_o | output | 1 | Standard sleep extension |
| xsleep_temp_o | output | 1 | Temporary sleep extension |
| lim_min_o | output | 6 | Lower bit-check limit |
| lim_max_o | output | 6 | Upper bit-check limit |
| off_pulse_o | output | 1 | One-cycle OFF command pulse |
| reset_marker_o | output | 1 | Register contents lost; reprogramming needed |

## Verification
The bench builds the block with its 12-bit registers and two synchronizer stages, so a full frame costs about a hundred core cycles and a sweep of 64 strided data words plus walking-one patterns through both registers fits easily. That reaches every field bit of both registers in both polarities, frames truncated at 1, 7 and 13 bits, over-long frames, OFF commands with random tails, and single and double register upsets with the marker cleared in either write order.

// File: rtl/rx_cfg_pkg.sv
package rx_cfg_pkg;
  localparam int unsigned CFG_W      = 12;
  localparam int unsigned NUM_REGS   = 2;
  localparam int unsigned REG_LIMIT  = 0;
  localparam int unsigned REG_OPMODE = 1;

  typedef struct packed {
    logic [1:0] baud;
    logic [1:0] bitchk;
    logic       pout;
    logic [4:0] sleep;
    logic       xs_std;
    logic       xs_temp;
  } opmode_t;

  typedef struct packed {
    logic [5:0] lim_lo;
    logic [5:0] lim_hi;
  } limit_t;

  localparam logic [CFG_W-1:0] OPMODE_RST = 12'h22C;
  localparam logic [CFG_W-1:0] LIMIT_RST  = 12'h398;
endpackage

// File: rtl/rx_cfg_sync.sv
module rx_cfg_sync #(
  parameter int unsigned WIDTH  = 1,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [STAGES-1:0][WIDTH-1:0] stg_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) stg_q <= '0;
        else         stg_q <= d_i;
      end
    end else begin : g_chain
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) stg_q <= '0;
        else         stg_q <= {stg_q[STAGES-2:0], d_i};
      end
    end
  endgenerate

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/rx_cfg_shift.sv
module rx_cfg_shift
  import rx_cfg_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             frame_i,
  input  logic             sclk_i,
  input  logic             sdata_i,
  output logic             off_o,
  output logic             we_o,
  output logic             sel_o,
  output logic [CFG_W-1:0] wdata_o
);
  localparam int unsigned FRAME_LEN = CFG_W + 2;
  localparam int unsigned CNT_W     = $clog2(FRAME_LEN + 1);
  localparam int unsigned SR_W      = FRAME_LEN - 1;

  logic             sclk_q, rise;
  logic [CNT_W-1:0] cnt_q;
  logic             done_q;
  logic [SR_W-1:0]  sr_q;
  logic             off_q, we_q, sel_q;
  logic [CFG_W-1:0] wdata_q;

  assign rise = sclk_i & ~sclk_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sclk_q  <= 1'b0;
      cnt_q   <= '0;
      done_q  <= 1'b0;
      sr_q    <= '0;
      off_q   <= 1'b0;
      we_q    <= 1'b0;
      sel_q   <= 1'b0;
      wdata_q <= '0;
    end else begin
      sclk_q <= sclk_i;
      off_q  <= 1'b0;
      we_q   <= 1'b0;
      if (!frame_i) begin
        cnt_q  <= '0;
        done_q <= 1'b0;
      end else if (rise && !done_q) begin
        sr_q  <= {sr_q[SR_W-2:0], sdata_i};
        cnt_q <= cnt_q + 1'b1;
        if (cnt_q == '0 && sdata_i) begin
          off_q  <= 1'b1;  // lone leading 1: OFF
          done_q <= 1'b1;
        end
        if (cnt_q == CNT_W'(FRAME_LEN - 1)) begin
          we_q    <= 1'b1;
          done_q  <= 1'b1;
          sel_q   <= sr_q[SR_W-2];  // address bit
          wdata_q <= {sr_q[CFG_W-2:0], sdata_i};
        end
      end
    end
  end

  assign off_o   = off_q;
  assign we_o    = we_q;
  assign sel_o   = sel_q;
  assign wdata_o = wdata_q;

  AST_CNT_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CNT_W'(FRAME_LEN)) else $error("count overrun"); // R7
  AST_ABORT_NO_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !frame_i |=> !we_q && !off_q) else $error("write after frame drop"); // R6
  AST_OFF_ONLY_FIRST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (frame_i && rise && !done_q && cnt_q != '0) |=> !off_q) else $error("late off"); // R5
endmodule

// File: rtl/rx_cfg_reg.sv
module rx_cfg_reg
  import rx_cfg_pkg::*;
#(
  parameter logic [CFG_W-1:0] RST_VAL = '0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [CFG_W-1:0] wdata_i,
  input  logic             upset_i,
  output logic [CFG_W-1:0] q_o,
  output logic             bad_o
);
  logic [CFG_W-1:0] data_q;
  logic             par_q, bad_q, mismatch;

  assign mismatch = (^data_q) != par_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_q <= RST_VAL;
      par_q  <= ^RST_VAL;
      bad_q  <= 1'b0;
    end else if (we_i) begin
      data_q <= wdata_i;
      par_q  <= ^wdata_i;
      bad_q  <= 1'b0;
    end else begin
      if (upset_i) data_q[0] <= ~data_q[0];  // models loss of stored content
      bad_q <= bad_q | mismatch;
    end
  end

  assign q_o   = data_q;
  assign bad_o = bad_q;

  AST_WRITE_LOADS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |=> (data_q == $past(wdata_i)) && !bad_q) else $error("write lost"); // R3
  AST_MARKER_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bad_q && !we_i) |=> bad_q) else $error("marker dropped"); // R8
  AST_PARITY_CATCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mismatch && !we_i) |=> bad_q) else $error("upset missed"); // R8
  AST_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!we_i && !upset_i) |=> $stable(data_q)) else $error("spurious change"); // R9
endmodule

// File: rtl/rx_cfg_loader.sv
module rx_cfg_loader
  import rx_cfg_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       frame_i,
  input  logic       sclk_i,
  input  logic       sdata_i,
  input  logic [1:0] upset_i,
  output logic [1:0] baud_o,
  output logic [1:0] bitchk_o,
  output logic       pout_o,
  output logic [4:0] sleep_o,
  output logic       xsleep_std_o,
  output logic       xsleep_temp_o,
  output logic [5:0] lim_min_o,
  output logic [5:0] lim_max_o,
  output logic       off_pulse_o,
  output logic       reset_marker_o
);
  localparam logic [NUM_REGS-1:0][CFG_W-1:0] RST_VALS = {OPMODE_RST, LIMIT_RST};

  logic [2:0]       sync_q;
  logic             off, we, sel;
  logic [CFG_W-1:0] wdata;
  logic [NUM_REGS-1:0][CFG_W-1:0] reg_q;
  logic [NUM_REGS-1:0]            bad;
  opmode_t          opm;
  limit_t           lim;

  rx_cfg_sync #(.WIDTH(3), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    ({frame_i, sclk_i, sdata_i}),
    .q_o    (sync_q)
  );

  rx_cfg_shift u_shift (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .frame_i (sync_q[2]),
    .sclk_i  (sync_q[1]),
    .sdata_i (sync_q[0]),
    .off_o   (off),
    .we_o    (we),
    .sel_o   (sel),
    .wdata_o (wdata)
  );

  generate
    for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
      rx_cfg_reg #(.RST_VAL(RST_VALS[g])) u_reg (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .we_i    (we && (sel == 1'(g))),
        .wdata_i (wdata),
        .upset_i (upset_i[g]),
        .q_o     (reg_q[g]),
        .bad_o   (bad[g])
      );
    end
  endgenerate

  assign opm            = opmode_t'(reg_q[REG_OPMODE]);
  assign lim            = limit_t'(reg_q[REG_LIMIT]);
  assign baud_o         = opm.baud;
  assign bitchk_o       = opm.bitchk;
  assign pout_o         = opm.pout;
  assign sleep_o        = opm.sleep;
  assign xsleep_std_o   = opm.xs_std;
  assign xsleep_temp_o  = opm.xs_temp;
  assign lim_min_o      = lim.lim_lo;
  assign lim_max_o      = lim.lim_hi;
  assign off_pulse_o    = off;
  assign reset_marker_o = |bad;

  AST_OFF_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    off_pulse_o |=> !off_pulse_o) else $error("wide off pulse"); // R5
  AST_OFF_NO_CHANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (off_pulse_o && upset_i == '0) |=> $stable(reg_q)) else $error("off changed regs"); // R5
  AST_MARKER_SRC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(reset_marker_o) |-> $past(upset_i != '0, 2) || $past(upset_i != '0)) else $error("marker without upset"); // R8
endmodule

// File: tb/rx_cfg_loader_tb.sv
`timescale 1ns/1ps
module rx_cfg_loader_tb;
  logic clk = 1'b0, rst_n = 1'b0;
  logic frame = 1'b0, sclk = 1'b0, sdata = 1'b0;
  logic [1:0] upset = 2'b00;
  logic [1:0] baud, bitchk;
  logic pout, xs_std, xs_temp, off_p, marker;
  logic [4:0] sleep;
  logic [5:0] lmin, lmax;

  int checks = 0, errors = 0;
  int off_cnt = 0, off_wide = 0;
  logic off_prev = 1'b0;
  logic [11:0] exp_op = 12'h22C, exp_lim = 12'h398;

  always #2.5 clk = ~clk;

  rx_cfg_loader u_dut (
    .clk_i(clk), .rst_ni(rst_n), .frame_i(frame), .sclk_i(sclk), .sdata_i(sdata),
    .upset_i(upset), .baud_o(baud), .bitchk_o(bitchk), .pout_o(pout), .sleep_o(sleep),
    .xsleep_std_o(xs_std), .xsleep_temp_o(xs_temp), .lim_min_o(lmin), .lim_max_o(lmax),
    .off_pulse_o(off_p), .reset_marker_o(marker)
  );

  always @(negedge clk) begin
    if (off_p) off_cnt++;
    if (off_p && off_prev) off_wide++;
    off_prev <= off_p;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic chk_regs(input string req);
    chk(req, {20'd0, baud, bitchk, pout, sleep, xs_std, xs_temp}, {20'd0, exp_op});
    chk(req, {20'd0, lmin, lmax}, {20'd0, exp_lim});
  endtask

  // n bits, first bit is bits[n-1]
  task automatic send(input int n, input logic [31:0] bits, input bit close = 1'b1);
    @(negedge clk) frame = 1'b1;
    repeat (2) @(negedge clk);
    for (int i = n - 1; i >= 0; i--) begin
      sdata = bits[i];
      repeat (3) @(negedge clk);
      sclk = 1'b1;
      repeat (3) @(negedge clk);
      sclk = 1'b0;
    end
    if (close) begin
      repeat (2) @(negedge clk);
      frame = 1'b0;
      repeat (8) @(negedge clk);
    end
  endtask

  task automatic prog(input bit op, input logic [11:0] d);
    send(14, {18'd0, 1'b0, op, d});
    if (op) exp_op = d; else exp_lim = d;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int oc;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    // R1 reset values
    chk("R1 baud", baud, 0);
    chk("R1 bitchk", bitchk, 2);
    chk("R1 pout", pout, 0);
    chk("R1 sleep", sleep, 11);
    chk("R1 xsleep", {xs_std, xs_temp}, 0);
    // R2
    chk("R2 lim_min", lmin, 14);
    chk("R2 lim_max", lmax, 24);
    chk("R2 marker", marker, 0);

    // R3/R4 strided sweep through both registers
    for (int k = 0; k < 64; k++) begin
      prog(1'b1, 12'((k * 167 + 5) % 4096));
      chk_regs("R3 mode load");
      prog(1'b0, 12'((k * 2731 + 9) % 4096));
      chk_regs("R4 limit load");
    end
    for (int b = 0; b < 12; b++) begin
      prog(1'b1, 12'(1 << b));
      chk_regs("R3 walking one");
      prog(1'b0, 12'(~(1 << b)));
      chk_regs("R4 walking zero");
    end
    prog(1'b1, 12'hD5A);
    chk("R3 baud field", baud, 3);
    chk("R3 bitchk field", bitchk, 1);
    chk("R3 pout field", pout, 0);
    chk("R3 sleep field", sleep, 5'b10110);
    chk("R3 xsleep fields", {xs_std, xs_temp}, 2'b10);
    prog(1'b0, {6'd40, 6'd9});
    chk("R4 lim fields", {lmin, lmax}, {6'd40, 6'd9});

    // R5 OFF command, with assorted tails
    oc = off_cnt;
    send(1, 32'h1);
    chk("R5 off pulse", off_cnt - oc, 1);
    chk_regs("R5 regs kept");
    for (int t = 0; t < 4; t++) begin
      oc = off_cnt;
      send(14, {18'd0, 1'b1, 13'((t * 3001) % 8192)});
      chk("R5 off with tail", off_cnt - oc, 1);
      chk_regs("R5 regs kept tail");
    end
    chk("R5 pulse width", off_wide, 0);

    // R6 aborted frames
    foreach (exp_op[i]) if (i == 0) begin end
    oc = off_cnt;
    send(13, {19'd0, 2'b01, 11'h7FF});
    chk_regs("R6 abort 13");
    send(7, {25'd0, 7'b0011111});
    chk_regs("R6 abort 7");
    send(1, 32'h0);
    chk_regs("R6 abort 1");
    chk("R6 no off", off_cnt - oc, 0);

    // R10 fresh frame after aborts
    prog(1'b0, 12'hA5C);
    chk_regs("R10 restart");

    // R7 over-long frame
    send(20, {12'd0, 1'b0, 1'b1, 12'h3C9, 6'b111111});
    exp_op = 12'h3C9;
    chk_regs("R7 extra bits");

    // R9 no partial update mid-word
    send(13, {19'd0, 1'b0, 1'b1, 11'h000}, 1'b0);
    repeat (8) @(negedge clk);
    chk_regs("R9 mid word");
    sdata = 1'b1;
    repeat (3) @(negedge clk); sclk = 1'b1;
    repeat (3) @(negedge clk); sclk = 1'b0;
    repeat (2) @(negedge clk); frame = 1'b0;
    repeat (8) @(negedge clk);
    exp_op = 12'h001;
    chk_regs("R9 after last bit");

    // R8 upset handling
    @(negedge clk) upset = 2'b10;
    @(negedge clk) upset = 2'b00;
    exp_op = exp_op ^ 12'h001;
    repeat (4) @(negedge clk);
    chk("R8 marker set", marker, 1);
    chk_regs("R8 upset content");
    prog(1'b0, 12'h111);
    chk("R8 other write keeps marker", marker, 1);
    prog(1'b1, 12'h222);
    chk("R8 rewrite clears", marker, 0);
    @(negedge clk) upset = 2'b11;
    @(negedge clk) upset = 2'b00;
    repeat (4) @(negedge clk);
    chk("R8 both upset", marker, 1);
    prog(1'b1, 12'h0F0);
    chk("R8 one of two rewritten", marker, 1);
    send(1, 32'h1);
    chk("R8 off does not clear", marker, 1);
    prog(1'b0, 12'h70E);
    chk("R8 both rewritten", marker, 0);
    chk_regs("R8 final regs");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule